// File: doc/BRIEF.md
# ECC RAM controller with initializer

This block wraps a small single-port on-chip RAM with single-error-correct, double-error-detect (SECDED) protection. Each stored word carries Hamming check bits and an overall parity bit. A read returns corrected data when one bit has flipped, and it marks the word as uncorrectable when two bits have flipped. An error event sets a sticky pending flag. Software clears that flag by writing a one to it. The interrupt output combines the pending flags with per-source enables and a mask, where the mask has its own set address and clear address.

A self-timed initialization engine prepares the memory. It writes zero data with matching check bits to every word, one word per clock. While it runs, the data port is blocked. When it finishes, a completion bit is raised and stays set until the next start. The engine is a three-state machine. INIT_IDLE is the state after reset. A start request moves it from INIT_IDLE to INIT_SWEEP. INIT_SWEEP writes address 0 up to DEPTH-1 and then moves to INIT_DONE on its last word. A start request in INIT_DONE moves it back to INIT_SWEEP. A start request made while in INIT_SWEEP has no effect.

Software drives the block through an 8-bit register address bus. Register writes take effect on the clock edge. Register reads are combinational from the address.

Top module: `eccram_ctrl`

## Requirements
- R1: After reset, the following registers read 0: control (0x08), init status (0x0C), interrupt status (0x20) and mask (0x24). After reset, `irq` is 0 and `mem_ready` is 1.
- R2: Writing bit 16 at 0x08 starts the engine and clears bit 0 of 0x0C. Exactly DEPTH clocks after the start edge, bit 0 of 0x0C reads 1. From then on every word reads back as zero with no error.
- R3: While the engine runs, `mem_ready` is 0 and port requests are ignored: no write lands and no read produces `mem_rvalid`.
- R4: With both bits 1:0 of 0x08 set, ECC is active. A word written and then read back is returned intact. `mem_rvalid` rises one clock after the read request edge.
- R5: With ECC active, a stored word with one flipped data bit is returned corrected, and bit 0 (single pending) of 0x20 is set.
- R6: With ECC active, a stored word with two flipped data bits is returned as stored with `mem_uncorr` = 1. Only bit 8 (double pending) of 0x20 is set.
- R7: Writing 1 to bit 0 or bit 8 of 0x20 clears that pending flag. Writing 0 to a bit leaves it unchanged.
- R8: `irq` = (single pending AND bit 0 of 0x10) OR (double pending AND bit 8 of 0x10), with each term further gated by its mask bit.
- R9: Writing 1s at 0x24 sets mask bits and writing 1s at 0x28 clears them. Mask bit 0 gates the single source and mask bit 1 gates the double source. A set mask bit blocks its source from `irq`. The mask reads back at 0x24.
- R10: When bits 1:0 of 0x08 are not both set, reads return the raw stored data, `mem_uncorr` stays 0, and no flag is set. Writes in this state replace the data bits but keep the old check bits.
- R11: When a clearing write to 0x20 and a new error event of the same kind fall in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | input | 1 | Data-port request |
| mem_we | input | 1 | Data-port write (1) or read (0) |
| mem_addr | input | ADDR_W | Data-port word address |
| mem_wdata | input | DATA_W | Data-port write data |
| mem_ready | output | 1 | Port accepts requests (low while initializing) |
| mem_rvalid | output | 1 | Read data valid |
| mem_rdata | output | DATA_W | Read data (corrected when possible) |
| mem_uncorr | output | 1 | Read word holds an uncorrectable error |
| irq | output | 1 | Error interrupt |

## Verification
Two events can fall in the same clock: the error-flag update driven by a read leaving the decoder, and a software write that clears that same flag. The bench creates this overlap on purpose. It first corrupts a word by writing it with ECC disabled, then re-enables ECC. It issues a read of that word, and on the very next clock issues the clearing write to 0x20, so the decoder event and the clear reach the flag register on one edge. The check passes only if the flag reads back as set, and a second clearing write must then remove it.

// File: rtl/eccram_pkg.sv
`timescale 1ns/1ps
package eccram_pkg;
    localparam int REG_W = 32;

    localparam logic [7:0] A_CTRL  = 8'h08;
    localparam logic [7:0] A_INIT  = 8'h0C;
    localparam logic [7:0] A_IE    = 8'h10;
    localparam logic [7:0] A_ISTAT = 8'h20;
    localparam logic [7:0] A_MSET  = 8'h24;
    localparam logic [7:0] A_MCLR  = 8'h28;

    localparam int START_BIT = 16;
    localparam int DBE_BIT   = 8;

    typedef enum logic [1:0] {
        INIT_IDLE  = 2'd0,
        INIT_SWEEP = 2'd1,
        INIT_DONE  = 2'd2
    } init_state_e;

    // Smallest Hamming check width that covers dw data bits.
    function automatic int check_width(int dw);
        int p = 1;
        while ((1 << p) < dw + p + 1) p++;
        return p;
    endfunction

    // Codeword position of data bit j: the j-th position that is not a power of two.
    function automatic int data_pos(int j);
        int pos = 0;
        int cnt = 0;
        for (int p = 3; p < 256; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j && pos == 0) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction
endpackage

// File: rtl/eccram_secded_enc.sv
`timescale 1ns/1ps
module eccram_secded_enc
    import eccram_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int P      = check_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    output logic [P:0]        chk
);
    function automatic logic [DATA_W-1:0] col_mask(int i);
        logic [DATA_W-1:0] m;
        for (int j = 0; j < DATA_W; j++) m[j] = ((data_pos(j) >> i) & 1) != 0;
        return m;
    endfunction

    logic [P-1:0] ham;

    for (genvar i = 0; i < P; i++) begin : g_col
        localparam logic [DATA_W-1:0] M = col_mask(i);
        assign ham[i] = ^(data & M);
    end

    // Top bit is the overall parity over data and Hamming bits.
    assign chk = {^{ham, data}, ham};
endmodule

// File: rtl/eccram_secded_dec.sv
`timescale 1ns/1ps
module eccram_secded_dec
    import eccram_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int P      = check_width(DATA_W)
) (
    input  logic [DATA_W-1:0] data,
    input  logic [P:0]        chk,
    output logic [DATA_W-1:0] cdata,
    output logic              single,
    output logic              double
);
    localparam logic [P-1:0] MAXPOS = P'(DATA_W + P);

    logic [P:0]   recomp;
    logic [P-1:0] syn;
    logic         pm;
    logic         in_range;

    eccram_secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (data),
        .chk  (recomp)
    );

    assign syn      = chk[P-1:0] ^ recomp[P-1:0];
    assign pm       = chk[P] ^ recomp[P] ^ (^syn);
    assign in_range = (syn <= MAXPOS);
    assign single   = pm && in_range;
    assign double   = (!pm && syn != '0) || (pm && !in_range);

    for (genvar j = 0; j < DATA_W; j++) begin : g_fix
        localparam int POS = data_pos(j);
        assign cdata[j] = data[j] ^ (single && syn == P'(POS));
    end
endmodule

// File: rtl/eccram_init_fsm.sv
`timescale 1ns/1ps
module eccram_init_fsm
    import eccram_pkg::*;
#(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    init_state_e       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INIT_IDLE:  if (start) state_d = INIT_SWEEP;
            INIT_SWEEP: if (addr_q == LAST) state_d = INIT_DONE;
            INIT_DONE:  if (start) state_d = INIT_SWEEP;
            default:    state_d = INIT_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INIT_IDLE;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == INIT_SWEEP) addr_q <= addr_q + 1'b1;
            else                       addr_q <= '0;
        end
    end

    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        wr_addr = addr_q;
        unique case (state_q)
            INIT_IDLE:  ;
            INIT_SWEEP: busy = 1'b1;
            INIT_DONE:  done = 1'b1;
            default:    ;
        endcase
        wr_en = busy;
    end
endmodule

// File: rtl/eccram_ctrl.sv
`timescale 1ns/1ps
module eccram_ctrl
    import eccram_pkg::*;
#(
    parameter  int DATA_W = 32,
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int P      = check_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_wdata,
    output logic              mem_ready,
    output logic              mem_rvalid,
    output logic [DATA_W-1:0] mem_rdata,
    output logic              mem_uncorr,
    output logic              irq
);
    logic [DATA_W-1:0] data_mem [DEPTH];
    logic [P:0]        chk_mem  [DEPTH];

    logic [1:0]        ctrl_en;
    logic              ie_sbe, ie_dbe;
    logic [1:0]        mask_q;
    logic              sbe_pend, dbe_pend;
    logic              ecc_on;
    logic              start, busy, init_done, init_wr;
    logic [ADDR_W-1:0] init_addr;
    logic              acc_wr, acc_rd;
    logic [P:0]        enc_chk;
    logic [DATA_W-1:0] rd_word, cdata;
    logic [P:0]        rd_chk;
    logic              rvalid_q, dec_single, dec_double;
    logic              sbe_evt, dbe_evt;
    logic              wr_ctrl, wr_ie, wr_istat, wr_mset, wr_mclr;
    logic              unused_bits;

    assign unused_bits = ^{reg_wdata[REG_W-1:START_BIT+1], reg_wdata[START_BIT-1:DBE_BIT+1],
                           reg_wdata[DBE_BIT-1:2]};

    assign ecc_on   = (ctrl_en == 2'b11);
    assign wr_ctrl  = reg_we && reg_addr == A_CTRL;
    assign wr_ie    = reg_we && reg_addr == A_IE;
    assign wr_istat = reg_we && reg_addr == A_ISTAT;
    assign wr_mset  = reg_we && reg_addr == A_MSET;
    assign wr_mclr  = reg_we && reg_addr == A_MCLR;
    assign start    = wr_ctrl && reg_wdata[START_BIT];

    eccram_init_fsm #(.DEPTH(DEPTH)) u_init (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .busy    (busy),
        .done    (init_done),
        .wr_en   (init_wr),
        .wr_addr (init_addr)
    );

    assign mem_ready = !busy;
    assign acc_wr    = mem_req && mem_we && !busy;
    assign acc_rd    = mem_req && !mem_we && !busy;

    eccram_secded_enc #(.DATA_W(DATA_W)) u_enc (
        .data (mem_wdata),
        .chk  (enc_chk)
    );

    // Zero data encodes to all-zero check bits, so the sweep stores zeros.
    always_ff @(posedge clk) begin
        if (init_wr) begin
            data_mem[init_addr] <= '0;
            chk_mem[init_addr]  <= '0;
        end else if (acc_wr) begin
            data_mem[mem_addr] <= mem_wdata;
            if (ecc_on) chk_mem[mem_addr] <= enc_chk;
        end
        if (acc_rd) begin
            rd_word <= data_mem[mem_addr];
            rd_chk  <= chk_mem[mem_addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rvalid_q <= 1'b0;
        else        rvalid_q <= acc_rd;
    end

    eccram_secded_dec #(.DATA_W(DATA_W)) u_dec (
        .data   (rd_word),
        .chk    (rd_chk),
        .cdata  (cdata),
        .single (dec_single),
        .double (dec_double)
    );

    assign sbe_evt    = rvalid_q && ecc_on && dec_single;
    assign dbe_evt    = rvalid_q && ecc_on && dec_double;
    assign mem_rvalid = rvalid_q;
    assign mem_rdata  = ecc_on ? cdata : rd_word;
    assign mem_uncorr = dbe_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en  <= 2'b00;
            ie_sbe   <= 1'b0;
            ie_dbe   <= 1'b0;
            mask_q   <= 2'b00;
            sbe_pend <= 1'b0;
            dbe_pend <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_en <= reg_wdata[1:0];
            if (wr_ie) begin
                ie_sbe <= reg_wdata[0];
                ie_dbe <= reg_wdata[DBE_BIT];
            end
            if (wr_mset)      mask_q <= mask_q | reg_wdata[1:0];
            else if (wr_mclr) mask_q <= mask_q & ~reg_wdata[1:0];
            // A new event wins over a same-cycle clear.
            if (sbe_evt)                          sbe_pend <= 1'b1;
            else if (wr_istat && reg_wdata[0])    sbe_pend <= 1'b0;
            if (dbe_evt)                          dbe_pend <= 1'b1;
            else if (wr_istat && reg_wdata[DBE_BIT]) dbe_pend <= 1'b0;
        end
    end

    assign irq = (sbe_pend && ie_sbe && !mask_q[0]) || (dbe_pend && ie_dbe && !mask_q[1]);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[1:0] = ctrl_en;
            A_INIT:  reg_rdata[0] = init_done;
            A_IE:    begin reg_rdata[0] = ie_sbe; reg_rdata[DBE_BIT] = ie_dbe; end
            A_ISTAT: begin reg_rdata[0] = sbe_pend; reg_rdata[DBE_BIT] = dbe_pend; end
            A_MSET:  reg_rdata[1:0] = mask_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/eccram_ctrl_sva.sv
`timescale 1ns/1ps
module eccram_ctrl_sva (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_sbe_req,
    input logic       mem_req,
    input logic       mem_ready,
    input logic       mem_rvalid,
    input logic       irq,
    input logic       init_done,
    input logic       busy,
    input logic       ecc_on,
    input logic       sbe_evt,
    input logic       dbe_evt,
    input logic       sbe_pend,
    input logic [1:0] mask_q
);
    // R2: completion appears only at the end of a sweep
    p_done_after_sweep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> $past(busy));

    // R3: a request refused while initializing yields no read data
    p_blocked_no_rvalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> !mem_rvalid);

    // R6: a double error never also counts as single
    p_dbe_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbe_evt |-> !sbe_evt);

    // R7: clear with no competing event drops the flag
    p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sbe_req && !sbe_evt) |=> !sbe_pend);

    // R9: both sources masked keeps the interrupt low
    p_mask_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == 2'b11) |-> !irq);

    // R10: no error events while checking is off
    p_bypass_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_on |-> (!sbe_evt && !dbe_evt));

    // R11: an event always leaves the flag set
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sbe_evt |=> sbe_pend);
endmodule

bind eccram_ctrl eccram_ctrl_sva u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_sbe_req (reg_we && reg_addr == 8'h20 && reg_wdata[0]),
    .mem_req     (mem_req),
    .mem_ready   (mem_ready),
    .mem_rvalid  (mem_rvalid),
    .irq         (irq),
    .init_done   (init_done),
    .busy        (busy),
    .ecc_on      (ecc_on),
    .sbe_evt     (sbe_evt),
    .dbe_evt     (dbe_evt),
    .sbe_pend    (sbe_pend),
    .mask_q      (mask_q)
);

// File: tb/eccram_ctrl_bench.sv
`timescale 1ns/1ps
module eccram_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 32;
    localparam int DEPTH      = 64;
    localparam int ADDR_W     = $clog2(DEPTH);
    localparam int WATCHDOG   = 20000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              reg_we;
    logic [7:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              mem_req, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_ready, mem_rvalid, mem_uncorr, irq;
    logic [DATA_W-1:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eccram_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_eccram_ctrl (
        .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
        .mem_req, .mem_we, .mem_addr, .mem_wdata,
        .mem_ready, .mem_rvalid, .mem_rdata, .mem_uncorr, .irq
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference: golden value (last ECC write) and raw stored value per word.
    logic [31:0] g_mem [DEPTH];
    logic [31:0] r_mem [DEPTH];
    logic        m_busy, m_done, m_rv, m_sp, m_dp, m_ie_s, m_ie_d;
    int          m_cnt;
    logic [1:0]  m_en, m_mask;
    logic [31:0] m_rg, m_rr;

    function automatic int ndiff(logic [31:0] a, logic [31:0] b);
        return $countones(a ^ b);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_rv <= 0; m_sp <= 0; m_dp <= 0;
            m_ie_s <= 0; m_ie_d <= 0; m_cnt <= 0; m_en <= 0; m_mask <= 0;
        end else begin
            if (reg_we && reg_addr == 8'h08) begin
                m_en <= reg_wdata[1:0];
            end
            if (reg_we && reg_addr == 8'h08 && reg_wdata[16] && !m_busy) begin
                m_busy <= 1; m_cnt <= 0; m_done <= 0;
            end else if (m_busy) begin
                if (m_cnt == DEPTH - 1) begin
                    m_busy <= 0; m_done <= 1;
                    for (int i = 0; i < DEPTH; i++) begin g_mem[i] <= 0; r_mem[i] <= 0; end
                end else m_cnt <= m_cnt + 1;
            end
            if (reg_we && reg_addr == 8'h10) begin m_ie_s <= reg_wdata[0]; m_ie_d <= reg_wdata[8]; end
            if (reg_we && reg_addr == 8'h24) m_mask <= m_mask | reg_wdata[1:0];
            else if (reg_we && reg_addr == 8'h28) m_mask <= m_mask & ~reg_wdata[1:0];
            if (m_rv && m_en == 2'b11 && ndiff(m_rr, m_rg) == 1) m_sp <= 1;
            else if (reg_we && reg_addr == 8'h20 && reg_wdata[0]) m_sp <= 0;
            if (m_rv && m_en == 2'b11 && ndiff(m_rr, m_rg) >= 2) m_dp <= 1;
            else if (reg_we && reg_addr == 8'h20 && reg_wdata[8]) m_dp <= 0;
            if (mem_req && !m_busy && mem_we) begin
                r_mem[mem_addr] <= mem_wdata;
                if (m_en == 2'b11) g_mem[mem_addr] <= mem_wdata;
                m_rv <= 0;
            end else if (mem_req && !m_busy) begin
                m_rv <= 1; m_rg <= g_mem[mem_addr]; m_rr <= r_mem[mem_addr];
            end else m_rv <= 0;
        end
    end

    // Every-clock comparison of all registered outputs against the reference.
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            logic        eirq;
            logic [31:0] ed;
            logic        eu;
            eirq = (m_sp && m_ie_s && !m_mask[0]) || (m_dp && m_ie_d && !m_mask[1]);
            check(mem_ready === !m_busy, "R3 ready", 64'(mem_ready), 64'(!m_busy));
            check(irq === eirq, "R8 irq", 64'(irq), 64'(eirq));
            check(mem_rvalid === m_rv, "R4 rvalid", 64'(mem_rvalid), 64'(m_rv));
            if (m_rv) begin
                if (m_en != 2'b11)             begin ed = m_rr; eu = 0; end
                else if (ndiff(m_rr, m_rg) < 2) begin ed = m_rg; eu = 0; end
                else                            begin ed = m_rr; eu = 1; end
                check(mem_rdata === ed, "R5 rdata", 64'(mem_rdata), 64'(ed));
                check(mem_uncorr === eu, "R6 uncorr", 64'(mem_uncorr), 64'(eu));
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !ended) begin
            errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
        end
    end

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic reg_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic mem_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        mem_req = 1; mem_we = 1; mem_addr = ADDR_W'(a); mem_wdata = d;
        @(posedge clk);
        @(negedge clk);
        mem_req = 0; mem_we = 0;
    endtask

    task automatic mem_rd_chk(input int a, input logic [31:0] ed, input logic eu, input string tag);
        @(negedge clk);
        mem_req = 1; mem_we = 0; mem_addr = ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        mem_req = 0;
        #1;
        check(mem_rvalid === 1'b1, tag, 64'(mem_rvalid), 64'(1));
        check(mem_rdata === ed, tag, 64'(mem_rdata), 64'(ed));
        check(mem_uncorr === eu, tag, 64'(mem_uncorr), 64'(eu));
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        #1;
        check(irq === e, tag, 64'(irq), 64'(e));
    endtask

    task automatic wait_done(output int n);
        n = 0;
        reg_addr = 8'h0C;
        do begin
            @(negedge clk);
            n++;
            #1;
        end while (!reg_rdata[0] && n < 4 * DEPTH);
    endtask

    initial begin
        int n;
        rst_n = 0; reg_we = 0; reg_addr = 0; reg_wdata = 0;
        mem_req = 0; mem_we = 0; mem_addr = 0; mem_wdata = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1 reset values
        reg_chk(8'h08, 0, "R1 ctrl");
        reg_chk(8'h0C, 0, "R1 init status");
        reg_chk(8'h20, 0, "R1 pending");
        reg_chk(8'h24, 0, "R1 mask");
        check(irq === 1'b0 && mem_ready === 1'b1, "R1 irq/ready", 64'({irq, mem_ready}), 64'(2'b01));

        // R2 sweep length
        reg_wr(8'h08, 32'h0001_0000);
        wait_done(n);
        check(n == DEPTH, "R2 sweep cycles", 64'(n), 64'(DEPTH));

        // R4 round trip with ECC active
        reg_wr(8'h08, 32'h3);
        reg_chk(8'h08, 32'h3, "R4 ctrl readback");
        mem_wr(1, 32'hA5A5_0F0F);
        mem_rd_chk(1, 32'hA5A5_0F0F, 0, "R4 word 1");
        mem_wr(2, 32'hFFFF_FFFF);
        mem_rd_chk(2, 32'hFFFF_FFFF, 0, "R4 word 2");
        mem_rd_chk(3, 32'h0, 0, "R2 swept word is zero");

        // R5 single flip corrected
        reg_wr(8'h08, 32'h0);
        mem_wr(5, 32'h0000_0008);
        reg_wr(8'h08, 32'h3);
        mem_rd_chk(5, 32'h0, 0, "R5 corrected");
        reg_chk(8'h20, 32'h1, "R5 single pending");
        irq_chk(0, "R8 irq disabled");
        reg_wr(8'h10, 32'h1);
        irq_chk(1, "R8 irq enabled");

        // R9 mask set/clear
        reg_wr(8'h24, 32'h1);
        irq_chk(0, "R9 masked");
        reg_chk(8'h24, 32'h1, "R9 mask readback");
        reg_wr(8'h28, 32'h1);
        irq_chk(1, "R9 unmasked");

        // R7 clear by writing one; zero leaves it
        reg_wr(8'h20, 32'h0);
        reg_chk(8'h20, 32'h1, "R7 zero write keeps flag");
        reg_wr(8'h20, 32'h1);
        reg_chk(8'h20, 32'h0, "R7 cleared");
        irq_chk(0, "R7 irq drops");

        // R6 double flip
        reg_wr(8'h08, 32'h0);
        mem_wr(6, 32'h0000_0030);
        reg_wr(8'h08, 32'h3);
        mem_rd_chk(6, 32'h0000_0030, 1, "R6 uncorrectable");
        reg_chk(8'h20, 32'h100, "R6 only double pending");
        reg_wr(8'h10, 32'h101);
        irq_chk(1, "R8 double source");
        reg_wr(8'h24, 32'h2);
        irq_chk(0, "R9 double masked");
        reg_wr(8'h28, 32'h2);
        reg_wr(8'h20, 32'h100);
        reg_chk(8'h20, 32'h0, "R7 double cleared");

        // R10 bypass
        reg_wr(8'h08, 32'h0);
        mem_rd_chk(5, 32'h0000_0008, 0, "R10 raw single");
        mem_rd_chk(6, 32'h0000_0030, 0, "R10 raw double");
        reg_wr(8'h08, 32'h1);
        mem_rd_chk(5, 32'h0000_0008, 0, "R10 one enable bit");
        reg_chk(8'h20, 32'h0, "R10 no flags");

        // R11 clear and new event in the same clock
        reg_wr(8'h08, 32'h3);
        @(negedge clk);
        mem_req = 1; mem_we = 0; mem_addr = ADDR_W'(5);
        @(posedge clk);
        @(negedge clk);
        mem_req = 0;
        reg_we = 1; reg_addr = 8'h20; reg_wdata = 32'h1;
        @(posedge clk);
        @(negedge clk);
        reg_we = 0;
        reg_chk(8'h20, 32'h1, "R11 set wins");
        reg_wr(8'h20, 32'h1);
        reg_chk(8'h20, 32'h0, "R11 later clear");

        // R2/R3 restart: port blocked, memory cleared
        reg_wr(8'h08, 32'h0001_0003);
        reg_chk(8'h0C, 32'h0, "R2 done cleared on start");
        @(negedge clk);
        check(mem_ready === 1'b0, "R3 ready low", 64'(mem_ready), 64'(0));
        mem_wr(10, 32'hDEAD_BEEF);
        wait_done(n);
        check(reg_rdata[0] === 1'b1, "R2 second sweep done", 64'(reg_rdata[0]), 64'(1));
        mem_rd_chk(1, 32'h0, 0, "R2 restart clears");
        mem_rd_chk(10, 32'h0, 0, "R3 blocked write dropped");
        mem_rd_chk(5, 32'h0, 0, "R2 corrupted word rewritten");

        repeat (3) @(negedge clk);
        summary();
    end
endmodule